// File: doc/BRIEF.md
# Sync Pulse Rate Meter

This block measures how fast a horizontal sync signal is running. The sync input is first brought into the local clock domain, and then each of its rising edges is counted. Counting happens only while a gate window is open. The window is timed by a single-cycle timebase tick, and it repeats once per measurement period. Between the end of the gate and the end of the period there is a short dead interval in which no edges are counted. At the period boundary the count is published to a pair of CPU-readable byte registers, and the counter restarts from zero.

There are two window lengths:
- **Long window.** The full 13-bit count is published. With a 32 ms gate, one unit of the high byte is 1 kHz and one unit of the 5-bit low field is 1/32 kHz.
- **Fast window.** This is a quarter-length window, so the result settles sooner. The count is an 11-bit value, and it fills only result bits [12:2]. Result bits [1:0] keep whatever they held before.

The upper byte of each published result goes straight to the high register. The lower five bits wait in a shadow buffer. That buffer is copied into the low register only when software reads the high register. Reading high and then low therefore always returns a coherent pair.

Top module: `sync_rate_meter`

## Requirements
- R1: After reset, every register read returns 0 until the first measurement period completes. The readable registers are high (address 0), low (address 1) and status (address 2).
- R2: The sync input passes through a two-flop synchroniser. Each rising edge that is detected while the gate is open adds one to the count. Edges that fall in the dead interval between gate end and period end are not counted.
- R3: In long mode, at each period boundary the high register takes count[12:5] and the shadow buffer takes count[4:0]. The count then restarts from zero for the next period.
- R4: In fast mode the count is 11 bits wide. At the boundary the high register takes count[10:3] and buffer bits [4:2] take count[2:0]. Buffer bits [1:0] keep their previous value.
- R5: The low register changes only on a read of the high register. That read copies the shadow buffer into the low register, so a low read issued before the high read returns the previous value.
- R6: In long mode the count saturates at 8191. An edge that arrives at saturation sets the overflow status, which reads as status bit 0. The overflow status is re-evaluated at every period boundary, so a later window that stays in range clears it.
- R7: In fast mode the count saturates at 2047 and sets the overflow status when it is exceeded. A saturated result publishes a high register of 0xFF and buffer bits [4:2] of 3'b111.
- R8: A read is issued with rd_en high and an address on rd_addr. Read data appears one cycle later:
  - address 0 returns the high register;
  - address 1 returns {3'b000, low[4:0]};
  - address 2 returns {7'b0, overflow};
  - address 3 returns 0.

  In a cycle after one without a read, rd_data is 0.
- R9: The mode input is sampled only at a period boundary. The window and result mapping for a period are the ones chosen at that period's start, and the first period after reset is long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Asynchronous horizontal sync pulse input |
| tick | input | 1 | Single-cycle timebase tick that paces the window |
| fast_mode | input | 1 | 1 selects the short window at reduced resolution |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register address: 0 high, 1 low, 2 status, 3 reserved |
| rd_data | output | 8 | Registered read data, valid one cycle after rd_en |

## Verification
The sync input is driven with square waves whose period divides the gate length exactly. This means each pulse rate has one exact expected count, whatever its phase relative to the window.

- **Slow rate in long mode.** This places non-zero values in both fields. A field placed at the wrong bit position, or edges counted during the dead interval, would show up as a wrong value.
- **Fastest rate in long and fast modes.** This drives the count past both saturation limits and so exercises overflow.
- **Two in-range fast rates after an overflow.** These show that the overflow status clears again. They also show that the two preserved low bits carry over from the earlier long-mode result.

Low reads issued both before and after the high read separate the shadow buffer from the visible low register.

// File: rtl/srm_pkg.sv
package srm_pkg;

   typedef enum logic [1:0] {
      REG_HI   = 2'd0,
      REG_LO   = 2'd1,
      REG_STAT = 2'd2,
      REG_NONE = 2'd3
   } srm_addr_e;

   localparam int ByteW = 8;

endpackage

// File: rtl/srm_timebase.sv
module srm_timebase #(
   parameter int LONG_GATE   = 1000,
   parameter int LONG_PERIOD = 1024,
   parameter int FAST_GATE   = 250,
   parameter int FAST_PERIOD = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic mode_i,
   output logic gate_open_o,
   output logic wrap_o,
   output logic mode_q_o
);

   localparam int PMAX = (LONG_PERIOD > FAST_PERIOD) ? LONG_PERIOD : FAST_PERIOD;
   localparam int PH_W = $clog2(PMAX + 1);

   generate
      if (LONG_GATE < 1 || LONG_GATE >= LONG_PERIOD) begin : g_bad_long
         $error("srm_timebase: long gate must be shorter than long period");
      end
      if (FAST_GATE < 1 || FAST_GATE >= FAST_PERIOD) begin : g_bad_fast
         $error("srm_timebase: fast gate must be shorter than fast period");
      end
   endgenerate

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] gate_end;
   logic [PH_W-1:0] per_last;
   logic            mode_q;

   always_comb begin
      if (mode_q) begin
         gate_end = PH_W'(FAST_GATE);
         per_last = PH_W'(FAST_PERIOD - 1);
      end else begin
         gate_end = PH_W'(LONG_GATE);
         per_last = PH_W'(LONG_PERIOD - 1);
      end
   end

   assign gate_open_o = (ph_q < gate_end);
   assign wrap_o      = tick_i && (ph_q == per_last);
   assign mode_q_o    = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= '0;
         mode_q <= 1'b0;
      end else if (wrap_o) begin
         ph_q   <= '0;
         mode_q <= mode_i;
      end else if (tick_i) begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assert_gate_shut_at_wrap_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |-> !gate_open_o);

   assert_mode_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_o |=> $stable(mode_q));

endmodule

// File: rtl/srm_edge_sync.sv
module srm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srm_edge_sync: at least two synchroniser stages needed");
      end
   endgenerate

   logic [STAGES:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi <= STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

   assert_single_cycle_rise_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/srm_pulse_counter.sv
module srm_pulse_counter #(
   parameter int CNT_W  = 13,
   parameter int FAST_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_i,
   input  logic             rise_i,
   input  logic             wrap_i,
   input  logic             fast_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);

   generate
      if (FAST_W < 1 || FAST_W >= CNT_W) begin : g_bad_width
         $error("srm_pulse_counter: fast width must be below counter width");
      end
   endgenerate

   localparam logic [CNT_W-1:0] LONG_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] FAST_MAX = CNT_W'((1 << FAST_W) - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic [CNT_W-1:0] limit;

   assign limit = fast_i ? FAST_MAX : LONG_MAX;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (wrap_i) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (gate_i && rise_i) begin
         if (cnt_q == limit) ovf_q <= 1'b1;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   assert_clear_after_wrap_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> (cnt_q == '0 && !ovf_q));

   assert_hold_when_shut_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_i && !wrap_i) |=> $stable(cnt_q));

   assert_fast_cap_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      fast_i |-> (cnt_q <= FAST_MAX));

   assert_ovf_at_cap_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> (cnt_q == limit));

endmodule

// File: rtl/srm_result_regs.sv
module srm_result_regs
   import srm_pkg::*;
#(
   parameter int CNT_W  = 13,
   parameter int FAST_W = 11,
   parameter int HI_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap_i,
   input  logic             fast_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             ovf_i,
   input  logic             rd_en_i,
   input  logic [1:0]       rd_addr_i,
   output logic [ByteW-1:0] rd_data_o
);

   localparam int LO_W   = CNT_W - HI_W;
   localparam int KEEP_W = CNT_W - FAST_W;
   localparam int FLO_W  = FAST_W - HI_W;

   generate
      if (HI_W != ByteW || LO_W < 1 || LO_W > ByteW) begin : g_bad_split
         $error("srm_result_regs: result split does not fit the byte registers");
      end
      if (FLO_W < 1) begin : g_bad_fast
         $error("srm_result_regs: fast count must exceed the high field");
      end
   endgenerate

   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] buf_q;
   logic [LO_W-1:0] low_q;
   logic            ovf_st_q;
   logic [LO_W-1:0] buf_fast;
   srm_addr_e       addr;

   assign addr     = srm_addr_e'(rd_addr_i);
   assign buf_fast = {cnt_i[FLO_W-1:0], buf_q[KEEP_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= '0;
         buf_q    <= '0;
         ovf_st_q <= 1'b0;
      end else if (wrap_i) begin
         ovf_st_q <= ovf_i;
         if (fast_i) begin
            hi_q  <= cnt_i[FAST_W-1 -: HI_W];
            buf_q <= buf_fast;
         end else begin
            hi_q  <= cnt_i[CNT_W-1 -: HI_W];
            buf_q <= cnt_i[LO_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q     <= '0;
         rd_data_o <= '0;
      end else if (rd_en_i) begin
         unique case (addr)
            REG_HI: begin
               rd_data_o <= hi_q;
               low_q     <= buf_q;
            end
            REG_LO:   rd_data_o <= ByteW'(low_q);
            REG_STAT: rd_data_o <= ByteW'(ovf_st_q);
            default:  rd_data_o <= '0;
         endcase
      end else begin
         rd_data_o <= '0;
      end
   end

   assert_low_only_on_hi_read_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en_i && rd_addr_i == 2'd0) |=> $stable(low_q));

   assert_idle_zero_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> (rd_data_o == '0));

   assert_status_tracks_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> (ovf_st_q == $past(ovf_i)));

endmodule

// File: rtl/sync_rate_meter.sv
module sync_rate_meter #(
   parameter int CNT_W       = 13,
   parameter int FAST_W      = 11,
   parameter int SYNC_STAGES = 2,
   parameter int LONG_GATE   = 1000,
   parameter int LONG_PERIOD = 1024,
   parameter int FAST_GATE   = 250,
   parameter int FAST_PERIOD = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_in,
   input  logic       tick,
   input  logic       fast_mode,
   input  logic       rd_en,
   input  logic [1:0] rd_addr,
   output logic [7:0] rd_data
);

   logic             gate_open;
   logic             wrap;
   logic             mode_q;
   logic             rise;
   logic [CNT_W-1:0] cnt;
   logic             ovf;

   srm_timebase #(
      .LONG_GATE  (LONG_GATE),
      .LONG_PERIOD(LONG_PERIOD),
      .FAST_GATE  (FAST_GATE),
      .FAST_PERIOD(FAST_PERIOD)
   ) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .mode_i     (fast_mode),
      .gate_open_o(gate_open),
      .wrap_o     (wrap),
      .mode_q_o   (mode_q)
   );

   srm_edge_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(sync_in),
      .rise_o (rise)
   );

   srm_pulse_counter #(
      .CNT_W (CNT_W),
      .FAST_W(FAST_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .gate_i(gate_open),
      .rise_i(rise),
      .wrap_i(wrap),
      .fast_i(mode_q),
      .cnt_o (cnt),
      .ovf_o (ovf)
   );

   srm_result_regs #(
      .CNT_W (CNT_W),
      .FAST_W(FAST_W),
      .HI_W  (8)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wrap_i   (wrap),
      .fast_i   (mode_q),
      .cnt_i    (cnt),
      .ovf_i    (ovf),
      .rd_en_i  (rd_en),
      .rd_addr_i(rd_addr),
      .rd_data_o(rd_data)
   );

endmodule

// File: tb/sim_sync_rate_meter.sv
module sim_sync_rate_meter;

   localparam int LG = 16800;
   localparam int LP = 16900;
   localparam int FG = 4200;
   localparam int FP = 4225;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_in = 1'b0;
   logic       tick = 1'b1;
   logic       fast_mode = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   int per = 8;
   bit done = 1'b0;
   bit pend = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   sync_rate_meter #(
      .LONG_GATE  (LG),
      .LONG_PERIOD(LP),
      .FAST_GATE  (FG),
      .FAST_PERIOD(FP)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_in  (sync_in),
      .tick     (tick),
      .fast_mode(fast_mode),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );

   // pulse source: square wave of period per clocks
   initial begin
      int pc = 0;
      forever begin
         @(negedge clk);
         sync_in = (pc < per / 2);
         pc = (pc >= per - 1) ? 0 : pc + 1;
      end
   end

   // driver: issue a read and push the expected byte
   task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
      @(negedge clk);
      rd_en   = 1'b1;
      rd_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   // monitor: compare one cycle after each read
   always @(posedge clk) pend <= rd_en;

   always @(negedge clk) begin
      if (pend) begin
         logic [7:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rd_data !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", t, rd_data, e);
         end
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      wait_cyc(10);
      @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(4);

      // R8: idle read data is zero
      @(negedge clk);
      checks++;
      if (rd_data !== 8'h00) begin
         errors++;
         $display("FAIL R8 idle: got %h expected 00", rd_data);
      end

      // R1: before any completed period everything reads zero
      rd(2'd0, 8'h00, "R1 high after reset");
      rd(2'd1, 8'h00, "R1 low after reset");
      rd(2'd2, 8'h00, "R1 status after reset");
      rd(2'd3, 8'h00, "R8 reserved address");

      // R2/R3: long mode, period 8 -> 2100 edges = 0x834
      wait_cyc(2 * LP + 200);
      rd(2'd1, 8'h00, "R5 low before first high read");
      rd(2'd0, 8'h41, "R3 long high field");
      rd(2'd1, 8'h14, "R3 long low field");
      rd(2'd2, 8'h00, "R6 no overflow in range");

      // R6: long mode, period 2 -> 8400 edges, saturate
      per = 2;
      wait_cyc(2 * LP + 200);
      rd(2'd1, 8'h14, "R5 low stale until high read");
      rd(2'd0, 8'hFF, "R6 long saturated high");
      rd(2'd1, 8'h1F, "R6 long saturated low");
      rd(2'd2, 8'h01, "R6 long overflow set");

      // R7/R9: switch to fast mode at the next boundary, period 2 -> 2100 > 2047
      fast_mode = 1'b1;
      wait_cyc(LP + 2 * FP + 200);
      rd(2'd0, 8'hFF, "R7 fast saturated high");
      rd(2'd1, 8'h1F, "R7 fast saturated low");
      rd(2'd2, 8'h01, "R7 fast overflow set");

      // R4: fast period 8 -> 525 = 0x20D, low {101,11}
      per = 8;
      wait_cyc(2 * FP + 200);
      rd(2'd0, 8'h41, "R4 fast high field");
      rd(2'd1, 8'h17, "R4 fast low keeps bits 1:0");
      rd(2'd2, 8'h00, "R6 overflow re-evaluated clear");

      // R4: fast period 4 -> 1050 = 0x41A, low {010,11}
      per = 4;
      wait_cyc(2 * FP + 200);
      rd(2'd0, 8'h83, "R4 fast high second rate");
      rd(2'd1, 8'h0B, "R4 fast low second rate");
      rd(2'd2, 8'h00, "R7 no overflow in range");

      wait_cyc(4);
      done = 1'b1;
      finish_run();
   end

endmodule